// File: doc/BRIEF.md
# Taken-Branch Squash and Fetch Redirect Control

This block steers the front end of a five-stage in-order pipeline whose conditional branches are resolved late, by default when the branch sits in the memory-access stage. By then the instructions behind it have already been fetched, decoded and perhaps executed along the fall-through path. When the resolving stage reports a taken branch, the block raises a kill line for each wrong-path instruction still in flight, so that instruction moves on as a NOP that writes no register and no memory. In the same cycle it switches the fetch PC multiplexer to the branch target.

One parameter picks between two policies. In squash mode every valid instruction younger than the branch is killed. In delay-slot mode a fixed number of instructions after the branch (two by default) always complete, whether the branch is taken or not. Only the valid instructions beyond those slots are killed. If bubbles leave fewer valid instructions behind the branch than there are slots, the redirect is put off until the missing slot instructions have been fetched from the sequential path. A front-end stall never hides a kill. When fetch is stalled during a redirect, the target is held and the fetch stage stays killed until the target is actually fetched.

Stage index 0 is fetch, and the index rises toward write-back. The resolving stage is `RESOLVE_STG`. The branch compare itself, prediction and data hazards are handled elsewhere.

Top module: `branch_squash_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after reset, `kill_o` is all zero and `pc_sel_o` is 0 (sequential fetch), even if a taken branch is presented.
- R2: In squash mode (`DELAY_EN`=0), a taken flag with `stage_valid_i[RESOLVE_STG]`=1 sets `kill_o[i]` for every valid stage i below `RESOLVE_STG`. In that same cycle it sets `pc_sel_o`=1 and drives `redirect_pc_o` with `br_target_i`.
- R3: When the taken flag is 0, or the resolving stage is not valid, and no redirect is pending, `kill_o` is zero and `pc_sel_o` is 0.
- R4: `kill_o` is never set for a stage whose valid bit is 0, nor for the resolving stage or any older stage.
- R5: Kill lines are raised whatever the value of `stall_i`.
- R6: If `stall_i` is 1 in a cycle with `pc_sel_o`=1, the next cycle again has `pc_sel_o`=1 with the same `redirect_pc_o`. A fetch-stage instruction killed at the branch keeps its kill while the stall lasts. The first cycle with `stall_i`=0 ends the redirect.
- R7: In delay-slot mode (`DELAY_EN`=1), the `NUM_SLOTS` valid instructions nearest the branch (highest stage index below `RESOLVE_STG`) are spared. Every other valid younger instruction is killed.
- R8: In delay-slot mode, when only k < `NUM_SLOTS` valid younger instructions exist, `pc_sel_o` stays 0 for `NUM_SLOTS`-k cycles with `stall_i`=0, the branch cycle included. It then goes to 1 with the stored target.
- R9: A taken flag that arrives while a redirect is pending is ignored: it kills nothing and leaves the stored target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_taken_i | input | 1 | Branch in the resolving stage is taken |
| br_target_i | input | ADDR_W | Target address of that branch |
| stage_valid_i | input | NUM_STAGES | Valid bit per stage, index 0 = fetch |
| stall_i | input | 1 | Front end holds; the fetch PC this cycle is not consumed |
| kill_o | output | NUM_STAGES | Per-stage kill, turns that stage's instruction into a NOP |
| pc_sel_o | output | 1 | Fetch PC select: 0 sequential, 1 redirect target |
| redirect_pc_o | output | ADDR_W | Redirect target address, meaningful when `pc_sel_o`=1 |

## Verification
The bench builds two instances with five stages, resolution in stage 3 and a 32-bit address. The first runs in squash mode. The second runs in delay-slot mode with two slots. The squash instance covers full and sparse valid patterns, a redirect held through a stall while the fetch stage stays killed, a taken flag ignored while a redirect is pending, and a reset that lands on a pending redirect. The delay-slot instance covers sparing with a full pipe and with bubbles, and redirects put off by one and by two slots, including a shortfall that begins under a stall.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_TARGET = 1'b1
  } pc_src_e;

  // width able to hold 0..n inclusive, never zero
  function automatic int owe_width(input int n);
    return $clog2(n + 2);
  endfunction

endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bsq_slot_picker.sv
module bsq_slot_picker #(
  parameter int RESOLVE_STG = 3,
  parameter int NUM_SLOTS   = 2,
  parameter bit DELAY_EN    = 1'b0,
  parameter int CW          = 2
) (
  input  logic [RESOLVE_STG-1:0] young_valid,
  output logic [RESOLVE_STG-1:0] kill_mask,
  output logic [CW-1:0]          shortfall
);

  generate
    if (DELAY_EN) begin : g_slots
      logic [RESOLVE_STG-1:0] spare;
      logic [CW-1:0]          taken_cnt;

      // walk from the instruction nearest the branch toward fetch
      always_comb begin
        spare     = '0;
        taken_cnt = '0;
        for (int i = RESOLVE_STG - 1; i >= 0; i--) begin
          if (young_valid[i] && (taken_cnt < CW'(NUM_SLOTS))) begin
            spare[i]  = 1'b1;
            taken_cnt = taken_cnt + CW'(1);
          end
        end
      end

      assign kill_mask = young_valid & ~spare;
      assign shortfall = CW'(NUM_SLOTS) - taken_cnt;
    end else begin : g_squash
      assign kill_mask = young_valid;
      assign shortfall = '0;
    end
  endgenerate

endmodule

// File: rtl/bsq_redirect_fsm.sv
module bsq_redirect_fsm
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [CW-1:0]     shortfall,
  input  logic              kill_fetch_now,
  input  logic              stall_i,
  input  logic [ADDR_W-1:0] target_i,
  output pc_src_e           pc_src,
  output logic [ADDR_W-1:0] pc_o,
  output logic              hold_kill,
  output logic              pend
);

  logic              pend_q, pend_d;
  logic              hold_q, hold_d;
  logic [CW-1:0]     owe_q, owe_d;
  logic [ADDR_W-1:0] tgt_q;
  logic              tgt_en;

  always_comb begin
    pend_d    = pend_q;
    hold_d    = hold_q;
    owe_d     = owe_q;
    tgt_en    = 1'b0;
    pc_src    = PC_SEQ;
    hold_kill = 1'b0;
    pc_o      = tgt_q;
    if (ev) begin
      tgt_en = 1'b1;
      pc_o   = target_i;
      if (shortfall == '0) begin
        pc_src = PC_TARGET;
        pend_d = stall_i;
        hold_d = kill_fetch_now;
        owe_d  = '0;
      end else begin
        pend_d = 1'b1;
        hold_d = 1'b0;
        owe_d  = stall_i ? shortfall : shortfall - CW'(1);
      end
    end else if (pend_q) begin
      if (owe_q != '0) begin
        if (!stall_i) owe_d = owe_q - CW'(1);
      end else begin
        pc_src    = PC_TARGET;
        hold_kill = hold_q;
        if (!stall_i) begin
          pend_d = 1'b0;
          hold_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      owe_q  <= '0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      owe_q  <= owe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= target_i;
  end

  assign pend = pend_q;

endmodule

// File: rtl/branch_squash_ctrl.sv
module branch_squash_ctrl
  import bsq_pkg::*;
#(
  parameter int NUM_STAGES  = 5,
  parameter int RESOLVE_STG = 3,
  parameter int ADDR_W      = 32,
  parameter bit DELAY_EN    = 1'b0,
  parameter int NUM_SLOTS   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  br_taken_i,
  input  logic [ADDR_W-1:0]     br_target_i,
  input  logic [NUM_STAGES-1:0] stage_valid_i,
  input  logic                  stall_i,
  output logic [NUM_STAGES-1:0] kill_o,
  output logic                  pc_sel_o,
  output logic [ADDR_W-1:0]     redirect_pc_o
);

  localparam int CW = owe_width(NUM_SLOTS);

  logic                   rst_sync_n;
  logic                   ev;
  logic                   pend;
  logic                   hold_kill;
  logic [RESOLVE_STG-1:0] kill_mask;
  logic [CW-1:0]          shortfall;
  pc_src_e                pc_src;

  bsq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ev = br_taken_i & stage_valid_i[RESOLVE_STG] & ~pend & rst_sync_n;

  bsq_slot_picker #(
    .RESOLVE_STG (RESOLVE_STG),
    .NUM_SLOTS   (NUM_SLOTS),
    .DELAY_EN    (DELAY_EN),
    .CW          (CW)
  ) u_pick (
    .young_valid (stage_valid_i[RESOLVE_STG-1:0]),
    .kill_mask   (kill_mask),
    .shortfall   (shortfall)
  );

  bsq_redirect_fsm #(
    .ADDR_W (ADDR_W),
    .CW     (CW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ev             (ev),
    .shortfall      (shortfall),
    .kill_fetch_now (kill_mask[0]),
    .stall_i        (stall_i),
    .target_i       (br_target_i),
    .pc_src         (pc_src),
    .pc_o           (redirect_pc_o),
    .hold_kill      (hold_kill),
    .pend           (pend)
  );

  assign pc_sel_o = (pc_src == PC_TARGET);

  generate
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_kill
      if (g == 0) begin : g_fetch
        assign kill_o[g] = stage_valid_i[g] & ((ev & kill_mask[g]) | hold_kill);
      end else if (g < RESOLVE_STG) begin : g_young
        assign kill_o[g] = stage_valid_i[g] & ev & kill_mask[g];
      end else begin : g_old
        assign kill_o[g] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int NUM_STAGES  = 5,
  parameter int RESOLVE_STG = 3,
  parameter int ADDR_W      = 32,
  parameter bit DELAY_EN    = 1'b0
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  br_taken_i,
  input logic [ADDR_W-1:0]     br_target_i,
  input logic [NUM_STAGES-1:0] stage_valid_i,
  input logic                  stall_i,
  input logic [NUM_STAGES-1:0] kill_o,
  input logic                  pc_sel_o,
  input logic [ADDR_W-1:0]     redirect_pc_o,
  input logic                  pend
);

  assert_kill_valid_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kill_o & ~stage_valid_i) == '0);

  assert_kill_young_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kill_o >> RESOLVE_STG) == '0);

  assert_same_cycle_redirect_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!DELAY_EN && br_taken_i && stage_valid_i[RESOLVE_STG] && !pend)
      |-> (pc_sel_o && redirect_pc_o == br_target_i));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!br_taken_i && !pend) |-> (!pc_sel_o && kill_o == '0));

  assert_hold_target_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_sel_o && stall_i) |=> (pc_sel_o && $stable(redirect_pc_o)));

  assert_ignore_pending_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend && br_taken_i) |-> ((kill_o >> 1) == '0));

endmodule

bind branch_squash_ctrl bsq_checker #(
  .NUM_STAGES  (NUM_STAGES),
  .RESOLVE_STG (RESOLVE_STG),
  .ADDR_W      (ADDR_W),
  .DELAY_EN    (DELAY_EN)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .br_taken_i    (br_taken_i),
  .br_target_i   (br_target_i),
  .stage_valid_i (stage_valid_i),
  .stall_i       (stall_i),
  .kill_o        (kill_o),
  .pc_sel_o      (pc_sel_o),
  .redirect_pc_o (redirect_pc_o),
  .pend          (pend)
);

// File: tb/tb_branch_squash_ctrl.sv
module tb_branch_squash_ctrl;

  localparam int NS = 5;
  localparam int AW = 32;

  logic clk;
  logic rst_n;

  logic          a_tk, a_st, b_tk, b_st;
  logic [AW-1:0] a_tgt, b_tgt;
  logic [NS-1:0] a_v, b_v;
  logic [NS-1:0] a_kill, b_kill;
  logic          a_sel, b_sel;
  logic [AW-1:0] a_pc, b_pc;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  branch_squash_ctrl #(.NUM_STAGES(NS), .RESOLVE_STG(3), .ADDR_W(AW),
                       .DELAY_EN(1'b0), .NUM_SLOTS(2)) dut (
    .clk(clk), .rst_n(rst_n), .br_taken_i(a_tk), .br_target_i(a_tgt),
    .stage_valid_i(a_v), .stall_i(a_st), .kill_o(a_kill),
    .pc_sel_o(a_sel), .redirect_pc_o(a_pc));

  branch_squash_ctrl #(.NUM_STAGES(NS), .RESOLVE_STG(3), .ADDR_W(AW),
                       .DELAY_EN(1'b1), .NUM_SLOTS(2)) dut_slot (
    .clk(clk), .rst_n(rst_n), .br_taken_i(b_tk), .br_target_i(b_tgt),
    .stage_valid_i(b_v), .stall_i(b_st), .kill_o(b_kill),
    .pc_sel_o(b_sel), .redirect_pc_o(b_pc));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        mode;   // 0 squash instance, 1 delay-slot instance
    logic        tk;
    logic [4:0]  v;
    logic        st;
    logic [15:0] tgt;
    logic [4:0]  ek;
    logic        es;
    logic [15:0] epc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    // squash instance
    '{1'b0,1'b0,5'b11111,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd3}, // R3 not taken
    '{1'b0,1'b1,5'b11111,1'b0,16'd100,5'b00111,1'b1,16'd100,8'd2}, // R2 full pipe
    '{1'b0,1'b1,5'b10111,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd3}, // R3 resolve stage invalid
    '{1'b0,1'b1,5'b01011,1'b1,16'd200,5'b00011,1'b1,16'd200,8'd5}, // R5 kill under stall, R4 bubble
    '{1'b0,1'b0,5'b00001,1'b1,16'd0,  5'b00001,1'b1,16'd200,8'd6}, // R6 held
    '{1'b0,1'b1,5'b01001,1'b1,16'd300,5'b00001,1'b1,16'd200,8'd9}, // R9 ignored
    '{1'b0,1'b0,5'b00001,1'b0,16'd0,  5'b00001,1'b1,16'd200,8'd6}, // R6 target fetched
    '{1'b0,1'b0,5'b11111,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd6}, // R6 redirect over
    '{1'b0,1'b1,5'b11000,1'b0,16'd400,5'b00000,1'b1,16'd400,8'd4}, // R4 nothing younger
    // delay-slot instance
    '{1'b1,1'b1,5'b11111,1'b0,16'd500,5'b00001,1'b1,16'd500,8'd7}, // R7 spare stages 2,1
    '{1'b1,1'b1,5'b01101,1'b0,16'd510,5'b00000,1'b1,16'd510,8'd7}, // R7 spare 2,0
    '{1'b1,1'b1,5'b01001,1'b0,16'd520,5'b00000,1'b0,16'd0,  8'd8}, // R8 one slot short
    '{1'b1,1'b0,5'b00001,1'b0,16'd0,  5'b00000,1'b1,16'd520,8'd8}, // R8 now redirect
    '{1'b1,1'b0,5'b11111,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd8},
    '{1'b1,1'b1,5'b01000,1'b1,16'd530,5'b00000,1'b0,16'd0,  8'd8}, // R8 two short, stalled
    '{1'b1,1'b0,5'b00000,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd8},
    '{1'b1,1'b0,5'b00001,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd8},
    '{1'b1,1'b0,5'b00011,1'b0,16'd0,  5'b00000,1'b1,16'd530,8'd8},
    '{1'b1,1'b0,5'b11111,1'b0,16'd0,  5'b00000,1'b0,16'd0,  8'd3}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_all();
    a_tk = 1'b0; a_st = 1'b0; a_v = '0; a_tgt = '0;
    b_tk = 1'b0; b_st = 1'b0; b_v = '0; b_tgt = '0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    idle_all();
    rst_n = 1'b0;
    // R1: taken branch presented during reset has no effect
    @(negedge clk);
    a_tk = 1'b1; a_v = 5'b11111; a_tgt = 32'd77;
    b_tk = 1'b1; b_v = 5'b11111; b_tgt = 32'd77;
    #2;
    check(a_kill == '0, 1, "kill in reset", 32'(a_kill), 0);
    check(a_sel == 1'b0, 1, "sel in reset", 32'(a_sel), 0);
    check(b_kill == '0, 1, "slot kill in reset", 32'(b_kill), 0);
    @(negedge clk);
    idle_all();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(a_sel == 1'b0 && a_kill == '0, 1, "idle after reset", 32'({a_kill, a_sel}), 0);

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      idle_all();
      if (TBL[r].mode == 1'b0) begin
        a_tk = TBL[r].tk; a_v = TBL[r].v; a_st = TBL[r].st; a_tgt = 32'(TBL[r].tgt);
      end else begin
        b_tk = TBL[r].tk; b_v = TBL[r].v; b_st = TBL[r].st; b_tgt = 32'(TBL[r].tgt);
      end
      #2;
      if (TBL[r].mode == 1'b0) begin
        check(a_kill == TBL[r].ek, int'(TBL[r].req), "kill", 32'(a_kill), 32'(TBL[r].ek));
        check(a_sel == TBL[r].es, int'(TBL[r].req), "pc_sel", 32'(a_sel), 32'(TBL[r].es));
        if (TBL[r].es)
          check(a_pc == 32'(TBL[r].epc), int'(TBL[r].req), "target", a_pc, 32'(TBL[r].epc));
      end else begin
        check(b_kill == TBL[r].ek, int'(TBL[r].req), "kill", 32'(b_kill), 32'(TBL[r].ek));
        check(b_sel == TBL[r].es, int'(TBL[r].req), "pc_sel", 32'(b_sel), 32'(TBL[r].es));
        if (TBL[r].es)
          check(b_pc == 32'(TBL[r].epc), int'(TBL[r].req), "target", b_pc, 32'(TBL[r].epc));
      end
    end

    // R1: reset landing on a pending redirect clears it
    @(negedge clk);
    idle_all();
    a_tk = 1'b1; a_v = 5'b01011; a_st = 1'b1; a_tgt = 32'd900;
    #2;
    check(a_sel == 1'b1, 5, "pending setup sel", 32'(a_sel), 1);
    @(negedge clk);
    a_tk = 1'b0; a_v = 5'b00001;
    rst_n = 1'b0;
    #2;
    check(a_sel == 1'b0, 1, "sel after mid reset", 32'(a_sel), 0);
    check(a_kill == '0, 1, "kill after mid reset", 32'(a_kill), 0);
    @(negedge clk);
    rst_n = 1'b1;
    a_st = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(a_sel == 1'b0 && a_kill == '0, 1, "idle after mid reset", 32'({a_kill, a_sel}), 0);

    // R2: taken branch after the second reset is serviced again
    @(negedge clk);
    a_tk = 1'b1; a_v = 5'b01110; a_tgt = 32'd1234;
    #2;
    check(a_kill == 5'b00110, 2, "kill sparse", 32'(a_kill), 32'h6);
    check(a_sel == 1'b1 && a_pc == 32'd1234, 2, "target sparse", a_pc, 32'd1234);
    @(negedge clk);
    idle_all();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule